// File: doc/BRIEF.md
# Iterative Wide-Dividend Divider with Divide-Error

This block divides a double-width dividend by a single-width divisor and returns a single-width quotient and remainder. The default width is 16, so the dividend is 32 bits. It is built from two halves: the upper word is shifted left by one word width and ORed with the lower word. A mode input selects between unsigned and two's-complement signed operation. Signed division works on operand magnitudes. The quotient is negated when the operand signs differ, and the remainder is negated when the dividend is negative. The quotient therefore truncates toward zero, and the remainder follows the sign of the dividend.

A command is accepted by pulsing `start_i` while the unit is idle. The operands are captured on that edge, and a restoring shift-subtract loop then produces one quotient bit per cycle. When the divisor is zero, or the quotient does not fit the result width in the selected mode, the unit does not update its result outputs. Instead it raises `err_o` alongside the completion pulse. The quotient-fits test for the upper bound is made when the operands are captured, so the loop never needs more iterations than there are quotient bits.

A compile-time switch, `FORCE_CF`, makes a carry-flag output go high after the first completed divide and stay high. Any surrounding flag logic can take that value as the carry state after a divide.

Top module: `wdiv_unit`

## Requirements
- R1: In unsigned mode (`signed_i`=0) the dividend is `{dvd_hi_i, dvd_lo_i}`. When the divisor is nonzero and the quotient is at most 0xFFFF, `quot_o` gets the floor quotient and `rem_o` gets the remainder. Example: 0x0001FFFE / 2 gives quotient 0xFFFF, remainder 0, and no error.
- R2: In signed mode (`signed_i`=1) both operands are two's complement. The quotient truncates toward zero, and a nonzero remainder has the sign of the dividend. Examples: -7/2 gives -3 r -1, 7/-2 gives -3 r 1, -7/-2 gives 3 r -1.
- R3: A zero divisor, in either mode, raises `err_o` with `done_o`. On that completion `quot_o` and `rem_o` keep the values they held before.
- R4: In unsigned mode, a quotient greater than 0xFFFF raises the error and leaves the results unchanged. Example: 0xFFFF0000 / 0xFFFF.
- R5: In signed mode, a quotient outside -32768..32767 raises the error and leaves the results unchanged. Examples: 0x80000000 / -1 and 0x00008000 / 1. A quotient of exactly -32768 is valid.
- R6: A start seen while idle is accepted on that clock edge, and `busy_o` is high after it. `done_o` is a single-cycle pulse that goes high exactly DW+1 edges after the accepting edge, and `busy_o` falls on that same edge. This latency is the same for results and for errors.
- R7: A `start_i` pulse while `busy_o` is high is ignored. The running divide completes with its original operands, and no additional completion follows.
- R8: After synchronous active-low reset, `busy_o`, `done_o`, `err_o` and `cf_o` are 0, and `quot_o` and `rem_o` are 0.
- R9: With `FORCE_CF`=1, `cf_o` goes to 1 with the first completion, whether it ends in a result or an error, and stays at 1. With `FORCE_CF`=0, `cf_o` stays 0.
- R10: `err_o` is high only together with `done_o`. On a successful completion `err_o` is 0 and both results update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Request a divide; honoured only while idle |
| signed_i | input | 1 | 1 = two's-complement mode, 0 = unsigned mode |
| dvd_hi_i | input | DW | Upper word of the dividend |
| dvd_lo_i | input | DW | Lower word of the dividend |
| dvsr_i | input | DW | Divisor |
| busy_o | output | 1 | A divide is in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Divide-error, valid with done_o |
| quot_o | output | DW | Last successful quotient |
| rem_o | output | DW | Last successful remainder |
| cf_o | output | 1 | Carry output forced by FORCE_CF |

## Verification
The bench builds the unit with DW=16 and FORCE_CF=1. The 16-bit width makes the named boundaries reachable with exact values: 0x80000000 by -1, 0xFFFF0000 by 0xFFFF, 0x0001FFFE by 2, and a signed quotient of exactly -32768 against one of +32768. Setting FORCE_CF=1 brings the carry output's set-and-hold behaviour within reach; with the default value that output would only ever read 0. Pseudo-random operands in both modes, some shaped so the quotient fits and some left raw so it overflows, exercise the shift-subtract loop and both error paths against the fixed 17-cycle completion time.

// File: rtl/wdiv_pkg.sv
// Shared types for the wide-dividend divider.
// Assumes nothing beyond IEEE 1800-2017 enum support.
package wdiv_pkg;

    // Control sequencer states of the divider.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } wdiv_state_e;

endpackage

// File: rtl/wdiv_operand_prep.sv
// Operand preparation: builds the double-width dividend, converts both
// operands to magnitudes in signed mode, records which result signs must
// be flipped, and flags errors visible before iterating (zero divisor, or
// upper magnitude word not below the divisor magnitude, which means the
// quotient magnitude needs more than DW bits).
// Assumes: purely combinational, DW >= 2.
module wdiv_operand_prep #(
    parameter int DW = 16
) (
    input  logic          signed_mode,
    input  logic [DW-1:0] dvd_hi,
    input  logic [DW-1:0] dvd_lo,
    input  logic [DW-1:0] dvsr,
    output logic [DW-1:0] mag_hi,
    output logic [DW-1:0] mag_lo,
    output logic [DW-1:0] mag_dvsr,
    output logic          q_neg,
    output logic          r_neg,
    output logic          pre_err
);
    localparam int NW = 2 * DW;

    logic [NW-1:0] dvd_full;
    logic [NW-1:0] dvd_mag;
    logic          dvd_is_neg;
    logic          dvsr_is_neg;

    // Form the dividend, take magnitudes and derive the early error.
    always_comb begin
        dvd_full    = {dvd_hi, dvd_lo};
        dvd_is_neg  = signed_mode & dvd_full[NW-1];
        dvsr_is_neg = signed_mode & dvsr[DW-1];
        dvd_mag     = dvd_is_neg ? (~dvd_full + NW'(1)) : dvd_full;
        mag_dvsr    = dvsr_is_neg ? (~dvsr + DW'(1)) : dvsr;
        mag_hi      = dvd_mag[NW-1:DW];
        mag_lo      = dvd_mag[DW-1:0];
        q_neg       = dvd_is_neg ^ dvsr_is_neg;
        r_neg       = dvd_is_neg;
        pre_err     = (mag_dvsr == '0) | (mag_hi >= mag_dvsr);
    end
endmodule

// File: rtl/wdiv_iter_core.sv
// Restoring shift-subtract engine. On load it takes the magnitude upper
// word as partial remainder and the lower word as quotient shifter; each
// step yields one quotient bit. After DW steps the shifter holds the
// quotient and the partial register the remainder.
// Assumes: upper word < divisor at load for a meaningful result (the
// caller discards the result otherwise).
module wdiv_iter_core #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          step,
    input  logic [DW-1:0] ld_hi,
    input  logic [DW-1:0] ld_lo,
    input  logic [DW-1:0] ld_dvsr,
    output logic [DW-1:0] q_mag,
    output logic [DW-1:0] r_mag,
    output logic          last_step
);
    localparam int CW = (DW > 2) ? $clog2(DW) : 1;

    logic [DW-1:0] part_r;
    logic [DW-1:0] shq_r;
    logic [DW-1:0] dsr_r;
    logic [CW-1:0] cnt_r;
    logic [DW:0]   trial;
    logic [DW:0]   diff;
    logic          fits;

    // Trial subtraction of the divisor from the shifted partial remainder.
    always_comb begin
        trial = {part_r, shq_r[DW-1]};
        diff  = trial - {1'b0, dsr_r};
        fits  = ~diff[DW];
    end

    // Load operands or advance one quotient bit per step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            part_r <= '0;
            shq_r  <= '0;
            dsr_r  <= '0;
            cnt_r  <= '0;
        end else if (load) begin
            part_r <= ld_hi;
            shq_r  <= ld_lo;
            dsr_r  <= ld_dvsr;
            cnt_r  <= '0;
        end else if (step) begin
            part_r <= fits ? diff[DW-1:0] : trial[DW-1:0];
            shq_r  <= {shq_r[DW-2:0], fits};
            cnt_r  <= cnt_r + CW'(1);
        end
    end

    assign q_mag     = shq_r;
    assign r_mag     = part_r;
    assign last_step = (cnt_r == CW'(DW - 1));
endmodule

// File: rtl/wdiv_result_fix.sv
// Result correction: re-applies signs to quotient and remainder and
// folds the late signed range check into the early error.
// Assumes: purely combinational; inputs stable in the finishing state.
module wdiv_result_fix #(
    parameter int DW = 16
) (
    input  logic          is_signed,
    input  logic          q_neg,
    input  logic          r_neg,
    input  logic          pre_err,
    input  logic [DW-1:0] q_mag,
    input  logic [DW-1:0] r_mag,
    output logic [DW-1:0] quot,
    output logic [DW-1:0] rem,
    output logic          err
);
    localparam logic [DW-1:0] NEG_LIMIT = {1'b1, {(DW-1){1'b0}}};

    logic range_bad;

    // Signed range test on the magnitude, then sign restoration.
    always_comb begin
        range_bad = q_neg ? (q_mag > NEG_LIMIT) : q_mag[DW-1];
        err       = pre_err | (is_signed & range_bad);
        quot      = q_neg ? (~q_mag + DW'(1)) : q_mag;
        rem       = r_neg ? (~r_mag + DW'(1)) : r_mag;
    end
endmodule

// File: rtl/wdiv_unit.sv
// Top of the wide-dividend divider: start/busy/done sequencing, capture
// of sign and early-error state, result registers that are written only
// on success, and the optional forced carry output.
// Assumes: synchronous active-low reset; operands valid with start_i.
module wdiv_unit #(
    parameter int DW       = 16,
    parameter bit FORCE_CF = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          signed_i,
    input  logic [DW-1:0] dvd_hi_i,
    input  logic [DW-1:0] dvd_lo_i,
    input  logic [DW-1:0] dvsr_i,
    output logic          busy_o,
    output logic          done_o,
    output logic          err_o,
    output logic [DW-1:0] quot_o,
    output logic [DW-1:0] rem_o,
    output logic          cf_o
);
    import wdiv_pkg::*;

    wdiv_state_e   state_r;
    logic          accept;
    logic          sgn_r, qneg_r, rneg_r, perr_r;
    logic          done_r, err_r, cf_r;
    logic [DW-1:0] quot_r, rem_r;

    logic [DW-1:0] p_hi, p_lo, p_dsr;
    logic          p_qneg, p_rneg, p_err;
    logic [DW-1:0] c_q, c_r;
    logic          c_last;
    logic [DW-1:0] f_q, f_r;
    logic          f_err;

    assign accept = start_i & (state_r == ST_IDLE);

    wdiv_operand_prep #(.DW(DW)) u_prep (
        .signed_mode (signed_i),
        .dvd_hi      (dvd_hi_i),
        .dvd_lo      (dvd_lo_i),
        .dvsr        (dvsr_i),
        .mag_hi      (p_hi),
        .mag_lo      (p_lo),
        .mag_dvsr    (p_dsr),
        .q_neg       (p_qneg),
        .r_neg       (p_rneg),
        .pre_err     (p_err)
    );

    wdiv_iter_core #(.DW(DW)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .step      (state_r == ST_RUN),
        .ld_hi     (p_hi),
        .ld_lo     (p_lo),
        .ld_dvsr   (p_dsr),
        .q_mag     (c_q),
        .r_mag     (c_r),
        .last_step (c_last)
    );

    wdiv_result_fix #(.DW(DW)) u_fix (
        .is_signed (sgn_r),
        .q_neg     (qneg_r),
        .r_neg     (rneg_r),
        .pre_err   (perr_r),
        .q_mag     (c_q),
        .r_mag     (c_r),
        .quot      (f_q),
        .rem       (f_r),
        .err       (f_err)
    );

    // Sequencer: idle -> run for DW steps -> finish -> idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_r <= ST_IDLE;
        end else begin
            case (state_r)
                ST_IDLE: if (accept) state_r <= ST_RUN;
                ST_RUN:  if (c_last) state_r <= ST_FIN;
                ST_FIN:  state_r <= ST_IDLE;
                default: state_r <= ST_IDLE;
            endcase
        end
    end

    // Capture mode, result signs and early error with the operands.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sgn_r  <= 1'b0;
            qneg_r <= 1'b0;
            rneg_r <= 1'b0;
            perr_r <= 1'b0;
        end else if (accept) begin
            sgn_r  <= signed_i;
            qneg_r <= p_qneg;
            rneg_r <= p_rneg;
            perr_r <= p_err;
        end
    end

    // Completion: pulse done, report error, write results only on success.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_r <= 1'b0;
            err_r  <= 1'b0;
            quot_r <= '0;
            rem_r  <= '0;
        end else if (state_r == ST_FIN) begin
            done_r <= 1'b1;
            err_r  <= f_err;
            if (!f_err) begin
                quot_r <= f_q;
                rem_r  <= f_r;
            end
        end else begin
            done_r <= 1'b0;
            err_r  <= 1'b0;
        end
    end

    // Forced carry output, set on completion when enabled.
    generate
        if (FORCE_CF) begin : g_cf_forced
            always_ff @(posedge clk) begin
                if (!rst_n)                 cf_r <= 1'b0;
                else if (state_r == ST_FIN) cf_r <= 1'b1;
            end
        end else begin : g_cf_off
            assign cf_r = 1'b0;
        end
    endgenerate

    assign busy_o = (state_r != ST_IDLE);
    assign done_o = done_r;
    assign err_o  = err_r;
    assign quot_o = quot_r;
    assign rem_o  = rem_r;
    assign cf_o   = cf_r;
endmodule

// File: rtl/wdiv_chk.sv
// Protocol and result-hold checks for wdiv_unit, attached by bind.
// Assumes: observes ports only; counts busy cycles locally.
module wdiv_chk #(
    parameter int DW       = 16,
    parameter bit FORCE_CF = 1'b0
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start_i,
    input logic          busy_o,
    input logic          done_o,
    input logic          err_o,
    input logic [DW-1:0] quot_o,
    input logic [DW-1:0] rem_o,
    input logic          cf_o
);
    logic [15:0] busy_cnt;

    // Length of the current busy stretch.
    always_ff @(posedge clk) begin
        if (!rst_n)      busy_cnt <= '0;
        else if (busy_o) busy_cnt <= busy_cnt + 16'd1;
        else             busy_cnt <= '0;
    end

    AST_IDLE_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o); // R6
    AST_BUSY_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> (busy_cnt == 16'(DW + 1))); // R7
    AST_DONE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && $past(busy_o))); // R6
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R6
    AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> done_o); // R10
    AST_ERR_KEEPS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> ($stable(quot_o) && $stable(rem_o))); // R3
    AST_CF_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (FORCE_CF && done_o) |-> cf_o); // R9
    AST_CF_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        cf_o |=> cf_o); // R9
endmodule

bind wdiv_unit wdiv_chk #(.DW(DW), .FORCE_CF(FORCE_CF)) u_wdiv_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .err_o   (err_o),
    .quot_o  (quot_o),
    .rem_o   (rem_o),
    .cf_o    (cf_o)
);

// File: tb/tb_wdiv_unit.sv
// Scoreboard bench: the driver pushes expected completions, the monitor
// pops and compares them at each done pulse.
module tb_wdiv_unit;
    localparam int  DW       = 16;
    localparam time CLK_PER  = 10;
    localparam int  LATENCY  = DW + 1;
    localparam int  WATCHDOG = 100000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic          signed_i = 1'b0;
    logic [DW-1:0] dvd_hi_i = '0;
    logic [DW-1:0] dvd_lo_i = '0;
    logic [DW-1:0] dvsr_i = '0;
    logic          busy_o, done_o, err_o, cf_o;
    logic [DW-1:0] quot_o, rem_o;

    typedef struct {
        int          acc_cyc;
        logic [15:0] q;
        logic [15:0] r;
        logic        err;
        string       tag;
    } exp_t;

    exp_t        sb[$];
    int          checks = 0;
    int          errors = 0;
    int          cyc = 0;
    int          dones = 0;
    logic [15:0] last_q = '0;
    logic [15:0] last_r = '0;
    logic [31:0] lfsr = 32'h1ACE_B00C;
    bit          finished = 0;

    wdiv_unit #(.DW(DW), .FORCE_CF(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .signed_i(signed_i),
        .dvd_hi_i(dvd_hi_i), .dvd_lo_i(dvd_lo_i), .dvsr_i(dvsr_i),
        .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
        .quot_o(quot_o), .rem_o(rem_o), .cf_o(cf_o)
    );

    always #(CLK_PER/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    function automatic logic [31:0] next_rand();
        lfsr = lfsr ^ (lfsr << 13);
        lfsr = lfsr ^ (lfsr >> 17);
        lfsr = lfsr ^ (lfsr << 5);
        return lfsr;
    endfunction

    // Reference model from the requirements.
    function automatic exp_t model(input bit sgn, input logic [15:0] hi,
                                   input logic [15:0] lo, input logic [15:0] d,
                                   input string tag);
        exp_t   e;
        longint n, dv, q, r;
        e.tag = tag;
        e.acc_cyc = 0;
        if (sgn) begin
            n  = longint'($signed({hi, lo}));
            dv = longint'($signed(d));
        end else begin
            n  = longint'({32'd0, hi, lo});
            dv = longint'({48'd0, d});
        end
        if (dv == 0) begin
            e.err = 1'b1;
        end else begin
            q = n / dv;
            r = n % dv;
            e.err = sgn ? (q > 32767 || q < -32768) : (q > 65535);
            if (!e.err) begin
                e.q = q[15:0];
                e.r = r[15:0];
            end
        end
        if (e.err) begin
            e.q = last_q;
            e.r = last_r;
        end else begin
            last_q = e.q;
            last_r = e.r;
        end
        return e;
    endfunction

    // Driver: issue one divide and wait for it to complete.
    task automatic run_op(input bit sgn, input logic [15:0] hi,
                          input logic [15:0] lo, input logic [15:0] d,
                          input string tag);
        exp_t e;
        @(negedge clk);
        signed_i = sgn; dvd_hi_i = hi; dvd_lo_i = lo; dvsr_i = d;
        start_i = 1'b1;
        e = model(sgn, hi, lo, d, tag);
        @(posedge clk);
        #1;
        e.acc_cyc = cyc;
        sb.push_back(e);
        @(negedge clk);
        start_i = 1'b0;
        while (busy_o) @(negedge clk);
    endtask

    // Monitor: compare each completion with the scoreboard head.
    always @(negedge clk) begin
        if (rst_n && done_o) begin
            dones++;
            if (sb.size() == 0) begin
                check(1'b0, "R7", "unexpected done", 1, 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(err_o == e.err, e.tag, "err", err_o, e.err);
                check(quot_o == e.q, e.tag, "quotient", quot_o, e.q);
                check(rem_o == e.r, e.tag, "remainder", rem_o, e.r);
                check((cyc - e.acc_cyc) == LATENCY, "R6", "done latency",
                      cyc - e.acc_cyc, LATENCY);
                check(cf_o == 1'b1, "R9", "cf after divide", cf_o, 1);
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        check(1'b0, "WDOG", "watchdog expired", cyc, WATCHDOG);
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R8: reset state
        check(busy_o == 0, "R8", "busy", busy_o, 0);
        check(done_o == 0, "R8", "done", done_o, 0);
        check(err_o == 0, "R8", "err", err_o, 0);
        check(cf_o == 0, "R8", "cf", cf_o, 0);
        check(quot_o == 0, "R8", "quotient", quot_o, 0);
        check(rem_o == 0, "R8", "remainder", rem_o, 0);

        run_op(0, 16'h0000, 16'd1000, 16'd7, "R1");
        run_op(0, 16'h0001, 16'hFFFE, 16'd2, "R1");
        run_op(0, 16'h1234, 16'h5678, 16'h4000, "R1");
        run_op(0, 16'hFFFF, 16'h0000, 16'hFFFF, "R4");
        run_op(0, 16'h0002, 16'h0000, 16'h0002, "R4");
        run_op(0, 16'h0000, 16'h0005, 16'h0000, "R3");
        run_op(1, 16'hFFFF, 16'hFFF9, 16'd2, "R2");
        run_op(1, 16'h0000, 16'd7, 16'hFFFE, "R2");
        run_op(1, 16'hFFFF, 16'hFFF9, 16'hFFFE, "R2");
        run_op(1, 16'h8000, 16'h0000, 16'hFFFF, "R5");
        run_op(1, 16'hFFFF, 16'h8000, 16'h0001, "R5");
        run_op(1, 16'h0000, 16'h8000, 16'h0001, "R5");
        run_op(1, 16'h1234, 16'h0000, 16'h0000, "R3");

        // R7: second start while busy must be ignored
        begin
            exp_t e;
            @(negedge clk);
            signed_i = 0; dvd_hi_i = 16'h0000; dvd_lo_i = 16'd300; dvsr_i = 16'd9;
            start_i = 1'b1;
            e = model(0, 16'h0000, 16'd300, 16'd9, "R7");
            @(posedge clk);
            #1;
            e.acc_cyc = cyc;
            sb.push_back(e);
            @(negedge clk);
            start_i = 1'b0;
            repeat (5) @(negedge clk);
            dvd_lo_i = 16'd50; dvsr_i = 16'd3; start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
            while (busy_o) @(negedge clk);
            repeat (LATENCY + 4) @(negedge clk);
            check(busy_o == 0, "R7", "busy after ignored start", busy_o, 0);
        end

        // Mixed pseudo-random operands in both modes.
        for (int i = 0; i < 60; i++) begin
            logic [31:0] a, b;
            logic [15:0] d, hi;
            a = next_rand();
            b = next_rand();
            d = b[15:0];
            hi = a[31:16];
            if (i % 3 == 0 && d != 0) hi = hi % d;
            if (i % 3 == 1) hi = {16{a[15]}};
            run_op(i[0], hi, a[15:0], d, i[0] ? "R2" : "R1");
        end

        repeat (4) @(negedge clk);
        check(sb.size() == 0, "R6", "pending completions", sb.size(), 0);
        check(cf_o == 1'b1, "R9", "cf held", cf_o, 1);
        finish_run();
    end
endmodule